// File: doc/BRIEF.md
# Interrupt Status Aggregator with Event Decimation

This block gathers single-cycle completion pulses from ten DMA channels and from a set of audio output event sources. It latches each pulse into a sticky status bit and gates each status bit with an enable bit of its own. It then reduces all gated bits to one interrupt line. Software reads the status through a small register port and acknowledges a source by writing 1 to its bit. A bit that is already set absorbs further pulses from its source, so a source cannot queue a second interrupt behind the first.

The audio sources fall into three groups: the four serial outputs together, and each of the two S/PDIF outputs on its own. Each group has a decimator that lets its periodic events (buffer empty, block complete) through on every event, every second event or every fourth event. Underflow events are errors and always bypass decimation. A decimator is a small state machine with states DEC_S0, DEC_S1, DEC_S2 and DEC_S3, which count the accepted event cycles since the last pass. The transitions are as follows:
- A write to the mode register takes any state to DEC_S0 (restart).
- In the every-event mode, an event keeps the machine in DEC_S0 and passes.
- In the every-second mode, an event moves DEC_S0 to DEC_S1. A further event moves DEC_S1 back to DEC_S0 and passes.
- In the every-fourth mode, events move the machine through DEC_S0, DEC_S1, DEC_S2 and DEC_S3 in turn. An event in DEC_S3 returns it to DEC_S0 and passes.

Top module: `irq_status_agg`

## Requirements
- R1: After reset every register reads zero (addresses 0 to 4) and `irq` is low.
- R2: A pulse on `chan_done[n]` sets bit 2n of the channel status register (address 0) on the next clock edge. Odd bits and bits 20 and above of addresses 0 and 1 always read zero.
- R3: A write to address 0 clears each channel status bit 2n that has a 1 in the write data. Bits written with 0 keep their value. Without such a write, a set bit stays set.
- R4: A pulse that arrives while a channel's bit is already set leaves no trace. After software clears the bit, it reads zero until a new pulse arrives.
- R5: Status bits set whether or not their enable bit is set. The channel enable register (address 1) uses the channel status layout (bit 2n for channel n), and an enable bit only gates `irq`.
- R6: `irq` is high exactly when some status bit and its enable bit are both 1, taken over both the channel pair (addresses 0/1) and the port pair (addresses 2/3).
- R7: If a status clear write and a new event for the same bit fall in one cycle, the bit stays set. Other bits cleared by that write still clear.
- R8: The port status register (address 2) and port enable register (address 3) share one layout:
  - bits 3:0: serial output buffer empty, one bit per output
  - bits 7:4: serial output underflow
  - bits 9:8: S/PDIF block complete, one bit per output
  - bits 11:10: S/PDIF underflow
  - bits 13:12: S/PDIF buffer empty
  Port status bits are sticky and clear on a write of 1. Underflow events set their bit at once, whatever the mode.
- R9: The mode register (address 4) has three 2-bit fields: bits 1:0 for the serial group, bits 3:2 for S/PDIF output 0 and bits 5:4 for S/PDIF output 1. Value 0 passes every event, 1 passes every second and 2 passes every fourth. Value 3 acts as 0. Each cycle with at least one periodic event of a group counts as one event, and only the events of a passing cycle set status.
- R10: A write to address 4 restarts all three decimators. An event in the cycle of that write is neither counted nor passed.
- R11: Addresses 5 to 7 read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| chan_done | input | 10 | DMA channel completion pulses |
| ser_empty | input | 4 | Serial output buffer-empty pulses |
| ser_under | input | 4 | Serial output underflow pulses |
| spd_done | input | 2 | S/PDIF block-complete pulses |
| spd_under | input | 2 | S/PDIF underflow pulses |
| spd_empty | input | 2 | S/PDIF buffer-empty pulses |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume the following about the inputs:
- Event inputs are one-cycle pulses.
- Enable bits change only through register writes.
- Status bits rise only in a cycle that carries an event.

Under these assumptions, `irq` can never rise in a quiet cycle, and a status bit can fall only in a cycle that writes address 0. The stimulus drives every pulse and every write for exactly one cycle, changes it only on the falling clock edge, and reads back only after the rising edge that applies it. The same-cycle cases (clear against event, mode write against event) are the only places where a write and an event are driven together.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    // register map
    localparam logic [2:0] ADDR_CHAN_STS = 3'd0;
    localparam logic [2:0] ADDR_CHAN_EN  = 3'd1;
    localparam logic [2:0] ADDR_PORT_STS = 3'd2;
    localparam logic [2:0] ADDR_PORT_EN  = 3'd3;
    localparam logic [2:0] ADDR_MODE     = 3'd4;

    // decimation mode field encoding
    typedef enum logic [1:0] {
        DEC_EVERY1 = 2'd0,
        DEC_EVERY2 = 2'd1,
        DEC_EVERY4 = 2'd2,
        DEC_ALIAS1 = 2'd3
    } dec_mode_e;

    // decimator count states
    typedef enum logic [1:0] {
        DEC_S0 = 2'd0,
        DEC_S1 = 2'd1,
        DEC_S2 = 2'd2,
        DEC_S3 = 2'd3
    } dec_state_e;

endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] sts_o
);

    logic [W-1:0] sts_q;

    // a new event outranks a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else begin
            sts_q <= (sts_q & ~clr_i) | set_i;
        end
    end

    assign sts_o = sts_q;

endmodule

// File: rtl/irq_decimator.sv
module irq_decimator
    import irq_agg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       restart_i,
    input  logic       evt_i,
    output logic       pass_o
);

    dec_state_e state_q;
    dec_state_e state_d;
    dec_mode_e  mode;

    assign mode = dec_mode_e'(mode_i);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DEC_S0;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (restart_i) begin
            state_d = DEC_S0;
        end else if (evt_i) begin
            unique case (mode)
                DEC_EVERY2: begin
                    unique case (state_q)
                        DEC_S0:  state_d = DEC_S1;
                        default: state_d = DEC_S0;
                    endcase
                end
                DEC_EVERY4: begin
                    unique case (state_q)
                        DEC_S0: state_d = DEC_S1;
                        DEC_S1: state_d = DEC_S2;
                        DEC_S2: state_d = DEC_S3;
                        DEC_S3: state_d = DEC_S0;
                    endcase
                end
                default: state_d = DEC_S0;
            endcase
        end
    end

    // output: pass on the terminal event of the active mode
    always_comb begin
        pass_o = 1'b0;
        if (evt_i && !restart_i) begin
            unique case (mode)
                DEC_EVERY2: pass_o = (state_q != DEC_S0);
                DEC_EVERY4: pass_o = (state_q == DEC_S3);
                default:    pass_o = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
    import irq_agg_pkg::*;
#(
    parameter int NUM_CHAN = 10,
    parameter int NUM_SER  = 4,
    parameter int NUM_SPD  = 2,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [2:0]          reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_CHAN-1:0] chan_done,
    input  logic [NUM_SER-1:0]  ser_empty,
    input  logic [NUM_SER-1:0]  ser_under,
    input  logic [NUM_SPD-1:0]  spd_done,
    input  logic [NUM_SPD-1:0]  spd_under,
    input  logic [NUM_SPD-1:0]  spd_empty,
    output logic                irq
);

    localparam int PORT_W  = 2 * NUM_SER + 3 * NUM_SPD;
    localparam int NUM_GRP = 1 + NUM_SPD;
    localparam int MODE_W  = 2 * NUM_GRP;

    logic                wr_chan_sts;
    logic                wr_chan_en;
    logic                wr_port_sts;
    logic                wr_port_en;
    logic                wr_mode;

    logic [NUM_CHAN-1:0] wdata_even;
    logic [NUM_CHAN-1:0] chan_clr;
    logic [NUM_CHAN-1:0] chan_sts;
    logic [NUM_CHAN-1:0] chan_en_q;
    logic [DATA_W-1:0]   chan_sts_rd;
    logic [DATA_W-1:0]   chan_en_rd;

    logic [PORT_W-1:0]   port_set;
    logic [PORT_W-1:0]   port_clr;
    logic [PORT_W-1:0]   port_sts;
    logic [PORT_W-1:0]   port_en_q;

    logic [MODE_W-1:0]   mode_q;
    logic [NUM_GRP-1:0]  grp_evt;
    logic [NUM_GRP-1:0]  grp_pass;
    logic [NUM_SPD-1:0]  spd_gate;

    logic                unused_wdata;

    assign unused_wdata = ^reg_wdata;

    // write decode
    assign wr_chan_sts = reg_wr && (reg_addr == ADDR_CHAN_STS);
    assign wr_chan_en  = reg_wr && (reg_addr == ADDR_CHAN_EN);
    assign wr_port_sts = reg_wr && (reg_addr == ADDR_PORT_STS);
    assign wr_port_en  = reg_wr && (reg_addr == ADDR_PORT_EN);
    assign wr_mode     = reg_wr && (reg_addr == ADDR_MODE);

    // channel bits sit at even positions of the bus word
    genvar n;
    generate
        for (n = 0; n < NUM_CHAN; n++) begin : g_chan_map
            assign wdata_even[n] = reg_wdata[2*n];
        end
        for (n = 0; n < DATA_W; n++) begin : g_chan_rd
            if ((n % 2 == 0) && (n < 2 * NUM_CHAN)) begin : g_even
                assign chan_sts_rd[n] = chan_sts[n/2];
                assign chan_en_rd[n]  = chan_en_q[n/2];
            end else begin : g_gap
                assign chan_sts_rd[n] = 1'b0;
                assign chan_en_rd[n]  = 1'b0;
            end
        end
    endgenerate

    assign chan_clr = wr_chan_sts ? wdata_even : '0;

    irq_sticky_bank #(.W(NUM_CHAN)) u_chan_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (chan_done),
        .clr_i (chan_clr),
        .sts_o (chan_sts)
    );

    // decimator group events: group 0 is the serial group, then one per S/PDIF output
    assign grp_evt[0] = |ser_empty;

    genvar g;
    generate
        for (g = 0; g < NUM_SPD; g++) begin : g_spd_evt
            assign grp_evt[g+1] = spd_done[g] | spd_empty[g];
            assign spd_gate[g]  = grp_pass[g+1];
        end
        for (g = 0; g < NUM_GRP; g++) begin : g_dec
            irq_decimator u_dec (
                .clk       (clk),
                .rst_n     (rst_n),
                .mode_i    (mode_q[2*g +: 2]),
                .restart_i (wr_mode),
                .evt_i     (grp_evt[g]),
                .pass_o    (grp_pass[g])
            );
        end
    endgenerate

    // port layout, MSB first: spd empty, spd underflow, spd done, ser underflow, ser empty
    assign port_set = {spd_empty & spd_gate,
                       spd_under,
                       spd_done & spd_gate,
                       ser_under,
                       ser_empty & {NUM_SER{grp_pass[0]}}};

    assign port_clr = wr_port_sts ? reg_wdata[PORT_W-1:0] : '0;

    irq_sticky_bank #(.W(PORT_W)) u_port_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (port_set),
        .clr_i (port_clr),
        .sts_o (port_sts)
    );

    // enable and mode registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_en_q <= '0;
            port_en_q <= '0;
            mode_q    <= '0;
        end else begin
            if (wr_chan_en) chan_en_q <= wdata_even;
            if (wr_port_en) port_en_q <= reg_wdata[PORT_W-1:0];
            if (wr_mode)    mode_q    <= reg_wdata[MODE_W-1:0];
        end
    end

    // read mux
    always_comb begin
        case (reg_addr)
            ADDR_CHAN_STS: reg_rdata = chan_sts_rd;
            ADDR_CHAN_EN:  reg_rdata = chan_en_rd;
            ADDR_PORT_STS: reg_rdata = DATA_W'(port_sts);
            ADDR_PORT_EN:  reg_rdata = DATA_W'(port_en_q);
            ADDR_MODE:     reg_rdata = DATA_W'(mode_q);
            default:       reg_rdata = '0;
        endcase
    end

    assign irq = (|(chan_sts & chan_en_q)) | (|(port_sts & port_en_q));

endmodule

// File: rtl/irq_status_agg_chk.sv
module irq_status_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int NUM_CHAN = 10,
    parameter int NUM_SER  = 4,
    parameter int NUM_SPD  = 2,
    parameter int DATA_W   = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [2:0]          reg_addr,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic [DATA_W-1:0]   reg_rdata,
    input logic [NUM_CHAN-1:0] chan_done,
    input logic [NUM_SER-1:0]  ser_empty,
    input logic [NUM_SER-1:0]  ser_under,
    input logic [NUM_SPD-1:0]  spd_done,
    input logic [NUM_SPD-1:0]  spd_under,
    input logic [NUM_SPD-1:0]  spd_empty,
    input logic [NUM_CHAN-1:0] chan_sts,
    input logic                irq
);

    logic [NUM_CHAN-1:0] wr_even;
    logic [DATA_W-1:0]   legal_mask;
    logic                any_evt;
    logic                clr_wr;

    genvar i;
    generate
        for (i = 0; i < NUM_CHAN; i++) begin : g_even
            assign wr_even[i] = reg_wdata[2*i];
        end
        for (i = 0; i < DATA_W; i++) begin : g_mask
            assign legal_mask[i] = (i % 2 == 0) && (i < 2 * NUM_CHAN);
        end
    endgenerate

    assign any_evt = (|chan_done) | (|ser_empty) | (|ser_under)
                   | (|spd_done) | (|spd_under) | (|spd_empty);
    assign clr_wr  = reg_wr && (reg_addr == ADDR_CHAN_STS);

    // R2
    chan_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|chan_done) |=> ((chan_sts & $past(chan_done)) == $past(chan_done)));

    // R3
    chan_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((chan_sts & $past(chan_sts)) == $past(chan_sts)));

    // R3
    chan_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((chan_sts & $past(wr_even & ~chan_done)) == '0));

    // R2
    chan_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_addr == ADDR_CHAN_STS) || (reg_addr == ADDR_CHAN_EN))
        |-> ((reg_rdata & ~legal_mask) == '0));

    // R6
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !reg_wr && !any_evt) |=> !irq);

endmodule

bind irq_status_agg irq_status_agg_chk #(
    .NUM_CHAN (NUM_CHAN),
    .NUM_SER  (NUM_SER),
    .NUM_SPD  (NUM_SPD),
    .DATA_W   (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .chan_done (chan_done),
    .ser_empty (ser_empty),
    .ser_under (ser_under),
    .spd_done  (spd_done),
    .spd_under (spd_under),
    .spd_empty (spd_empty),
    .chan_sts  (chan_sts),
    .irq       (irq)
);

// File: tb/irq_status_agg_tb.sv
`timescale 1ns/1ps
module irq_status_agg_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic [9:0]  chan_done = '0;
    logic [3:0]  ser_empty = '0;
    logic [3:0]  ser_under = '0;
    logic [1:0]  spd_done = '0;
    logic [1:0]  spd_under = '0;
    logic [1:0]  spd_empty = '0;
    logic        irq;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    irq_status_agg u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .chan_done (chan_done),
        .ser_empty (ser_empty),
        .ser_under (ser_under),
        .spd_done  (spd_done),
        .spd_under (spd_under),
        .spd_empty (spd_empty),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // apply currently driven inputs for one edge, then drop the strobes
    task automatic step();
        @(negedge clk);
        reg_wr    = 1'b0;
        chan_done = '0;
        ser_empty = '0;
        ser_under = '0;
        spd_done  = '0;
        spd_under = '0;
        spd_empty = '0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic tidy();
        wr(3'd2, 32'h3FFF);
        wr(3'd0, 32'h000F_FFFF);
        wr(3'd1, 32'h0);
        wr(3'd3, 32'h0);
        wr(3'd4, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            chk("R1 reset read", d, 32'h0);
        end
        chk("R1 reset irq", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_chan_set();
        logic [31:0] d;
        chan_done = 10'b10_0000_0101;
        step();
        rd(3'd0, d);
        chk("R2 even-bit status", d, 32'h0004_0011);
        chk("R5 status without enable, irq low", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        for (int a = 5; a < 8; a++) begin
            rd(3'(a), d);
            chk("R11 unmapped read", d, 32'h0);
        end
        rd(3'd0, d);
        chk("R11 status untouched", d, 32'h0004_0011);
        rd(3'd1, d);
        chk("R11 enable untouched", d, 32'h0);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        wr(3'd0, 32'hAAAA_AAAA | 32'h10);
        rd(3'd0, d);
        chk("R3 clear one bit", d, 32'h0004_0001);
        wr(3'd0, 32'h0);
        rd(3'd0, d);
        chk("R3 zero write no effect", d, 32'h0004_0001);
        wr(3'd0, 32'h000F_FFFF);
        rd(3'd0, d);
        chk("R3 clear all", d, 32'h0);
    endtask

    task automatic t_absorb();
        logic [31:0] d;
        chan_done = 10'b00_0000_1000;
        step();
        chan_done = 10'b00_0000_1000;
        step();
        rd(3'd0, d);
        chk("R4 set once", d, 32'h0000_0040);
        wr(3'd0, 32'h40);
        rd(3'd0, d);
        chk("R4 second pulse not queued", d, 32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        wr(3'd1, 32'h5555_5555);
        rd(3'd1, d);
        chk("R5 enable layout", d, 32'h0005_5555);
        chk("R6 no status, irq low", {31'd0, irq}, 32'h0);
        chan_done = 10'b10_0000_0000;
        step();
        chk("R6 enabled status raises irq", {31'd0, irq}, 32'h1);
        wr(3'd1, 32'h0);
        chk("R5 enable off drops irq", {31'd0, irq}, 32'h0);
        rd(3'd0, d);
        chk("R5 status kept", d, 32'h0004_0000);
        tidy();
    endtask

    task automatic t_collide();
        logic [31:0] d;
        chan_done = 10'b00_0000_0011;
        step();
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h5;
        chan_done = 10'b00_0000_0010;
        step();
        rd(3'd0, d);
        chk("R7 event beats clear", d, 32'h0000_0004);
        tidy();
    endtask

    task automatic t_port_under();
        logic [31:0] d;
        ser_under = 4'b0100;
        spd_under = 2'b10;
        step();
        rd(3'd2, d);
        chk("R8 underflow bits", d, 32'h0000_0840);
        wr(3'd4, 32'h2);
        ser_under = 4'b0001;
        step();
        rd(3'd2, d);
        chk("R8 underflow bypasses decimation", d, 32'h0000_0850);
        wr(3'd3, 32'h10);
        chk("R6 port pair raises irq", {31'd0, irq}, 32'h1);
        wr(3'd2, 32'h10);
        chk("R8 port clear drops irq", {31'd0, irq}, 32'h0);
        tidy();
    endtask

    task automatic t_dec_two();
        logic [31:0] d;
        ser_empty = 4'b0010;
        step();
        rd(3'd2, d);
        chk("R9 mode 0 every event", d, 32'h0000_0002);
        wr(3'd2, 32'h3FFF);
        wr(3'd4, 32'h1);
        ser_empty = 4'b0001;
        step();
        rd(3'd2, d);
        chk("R9 mode 1 first event held", d, 32'h0);
        ser_empty = 4'b0100;
        step();
        rd(3'd2, d);
        chk("R9 mode 1 second event passes", d, 32'h0000_0004);
        wr(3'd2, 32'h3FFF);
        ser_empty = 4'b0001;
        step();
        rd(3'd2, d);
        chk("R9 mode 1 third event held", d, 32'h0);
        ser_empty = 4'b0001;
        step();
        rd(3'd2, d);
        chk("R9 mode 1 fourth event passes", d, 32'h0000_0001);
        tidy();
    endtask

    task automatic t_dec_four();
        logic [31:0] d;
        wr(3'd4, 32'h8);
        for (int k = 0; k < 3; k++) begin
            spd_done = 2'b01;
            step();
        end
        rd(3'd2, d);
        chk("R9 mode 2 three events held", d, 32'h0);
        spd_done = 2'b01;
        step();
        rd(3'd2, d);
        chk("R9 mode 2 fourth event passes", d, 32'h0000_0100);
        spd_empty = 2'b10;
        ser_empty = 4'b1000;
        step();
        rd(3'd2, d);
        chk("R9 other groups in mode 0", d, 32'h0000_2108);
        wr(3'd2, 32'h3FFF);
        wr(3'd4, 32'h30);
        spd_done = 2'b10;
        step();
        rd(3'd2, d);
        chk("R9 mode 3 acts as 0", d, 32'h0000_0200);
        tidy();
    endtask

    task automatic t_restart();
        logic [31:0] d;
        wr(3'd4, 32'h8);
        spd_done = 2'b01; step();
        spd_done = 2'b01; step();
        wr(3'd4, 32'h8);
        for (int k = 0; k < 3; k++) begin
            spd_done = 2'b01;
            step();
        end
        rd(3'd2, d);
        chk("R10 mode write restarts count", d, 32'h0);
        spd_done = 2'b01;
        step();
        rd(3'd2, d);
        chk("R10 pass after restart", d, 32'h0000_0100);
        wr(3'd2, 32'h3FFF);
        reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h1;
        ser_empty = 4'b0001;
        step();
        rd(3'd2, d);
        chk("R10 event in write cycle not passed", d, 32'h0);
        ser_empty = 4'b0001;
        step();
        rd(3'd2, d);
        chk("R10 event in write cycle not counted", d, 32'h0);
        ser_empty = 4'b0001;
        step();
        rd(3'd2, d);
        chk("R10 count resumes", d, 32'h0000_0001);
        tidy();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog R1..: act=timeout exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_chan_set();
        t_unmapped();
        t_w1c();
        t_absorb();
        t_enable();
        t_collide();
        t_port_under();
        t_dec_two();
        t_dec_four();
        t_restart();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule